// File: doc/BRIEF.md
# Byte/Word Flash Bus Interface

This block sits between the parallel pins of a NOR-style flash device and the rest of the device. It turns the three active-low strobes (chip enable, output enable, write enable) into read cycles and write cycles. It drives the data pins or leaves them floating, and it places data on the correct byte lanes. A static width input selects either a 16-bit word bus or an 8-bit byte bus. In byte mode the top data pin becomes an extra address input that picks the low or high half of the addressed word.

The storage behind the interface is a small resettable register file of 16-bit words. An identification input switches reads to a separate table of 8-bit codes, indexed by the low word-address bits. The block samples all pins on the rising clock edge. Array writes take effect on that edge. Read data and the per-pin output enables are registered, so they appear one edge after the strobes that request them. The pad ring combines `dq_o` and `dq_oe` into the real tri-state pins.

Top module: `flash_bus_if`

## Requirements
- R1: Reset, active low and asynchronous, clears every output enable and every stored word to zero. A read after reset returns 0x0000.
- R2: In word mode (`word_mode`=1), a read (`ce_n`=0, `oe_n`=0, `we_n`=1) sampled at an edge sets all sixteen bits of `dq_oe` to 1 and presents the addressed 16-bit word on `dq_o` after that edge.
- R3: In word mode, a write (`ce_n`=0, `we_n`=0, `oe_n`=1) stores `dq_i[15:0]` into the addressed word at the sampling edge.
- R4: In byte mode (`word_mode`=0), a read sets `dq_oe`=0x00FF. It presents one byte of the addressed word on `dq_o[7:0]`: the low byte when `dq_i[15]`=0, the high byte when `dq_i[15]`=1.
- R5: In byte mode, a write stores `dq_i[7:0]` into the half of the addressed word chosen by `dq_i[15]` (0 low, 1 high). The other half keeps its value.
- R6: In byte mode, `dq_oe[15:8]` is always 0. Values on `dq_i[14:8]` have no effect on stored data or read data.
- R7: With `ce_n`=1, no pin is driven, and a low `we_n` or a low `oe_n` changes nothing.
- R8: With `ce_n`=0 and both `oe_n` and `we_n` low, no write occurs and no pin is driven.
- R9: With `id_mode`=1, a read returns code ID_BASE + ID_STEP*`addr[1:0]` (default 0x01 + 0x22*index) on `dq_o[7:0]`. In word mode, `dq_o[15:8]` is driven as 0. The enables are the same as in R2 and R4. Writes in this mode still update the array.
- R10: Outputs change only at a clock edge. A read sampled one edge after a write to the same word returns the new data.
- R11: With `ce_n`=0 and both `oe_n` and `we_n` high, no pin is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_mode | input | 1 | 1: 16-bit bus, 0: 8-bit bus |
| id_mode | input | 1 | 1: reads return identification codes |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| dq_i | input | 16 | Data pins as seen from the pads; bit 15 is the byte address in byte mode |
| dq_o | output | 16 | Data to drive onto the pins |
| dq_oe | output | 16 | Per-pin drive enable |

## Verification
A write request and a read request can be asserted in the same cycle when the host pulls `we_n` and `oe_n` low together. The bench does this with `ce_n` low, on a word whose contents are already known. It then reads that word back on the next edge. The case passes only if no pin was driven during the contended cycle and the read-back data has not changed. The same read-back approach judges a write attempted with the chip deselected.

// File: rtl/flash_bus_pkg.sv
`timescale 1ns/1ps
package flash_bus_pkg;
  localparam int BUS_W  = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = BUS_W / LANE_W;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;
endpackage

// File: rtl/flash_cycle_decode.sv
`timescale 1ns/1ps
module flash_cycle_decode
  import flash_bus_pkg::*;
(
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output cyc_e cyc
);
  logic sel;
  assign sel = !ce_n;

  always_comb begin
    cyc = CYC_IDLE;
    if (sel && !oe_n && we_n)      cyc = CYC_READ;
    else if (sel && !we_n && oe_n) cyc = CYC_WRITE;
  end
endmodule

// File: rtl/flash_word_array.sv
`timescale 1ns/1ps
module flash_word_array
  import flash_bus_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_be,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BUS_W-1:0]  rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][BUS_W-1:0] mem_q;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic lane_en;
      assign lane_en = wr_be[l] && (wr_addr == ADDR_W'(w));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mem_q[w][l*LANE_W +: LANE_W] <= '0;
        else if (lane_en) mem_q[w][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rd_data = mem_q[rd_addr];

  // R3
  lane_lo_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_be[0] |=> mem_q[$past(wr_addr)][LANE_W-1:0] == $past(wr_data[LANE_W-1:0]));

  // R5
  lane_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_be[1] |=> mem_q[$past(wr_addr)][BUS_W-1:LANE_W] == $past(mem_q[wr_addr][BUS_W-1:LANE_W]));
endmodule

// File: rtl/flash_lane_path.sv
`timescale 1ns/1ps
module flash_lane_path
  import flash_bus_pkg::*;
#(
  parameter int          ID_SEL_W = 2,
  parameter logic [7:0]  ID_BASE  = 8'h01,
  parameter logic [7:0]  ID_STEP  = 8'h22
) (
  input  cyc_e                cyc,
  input  logic                word_mode,
  input  logic                id_mode,
  input  logic [ID_SEL_W-1:0] id_sel,
  input  logic [BUS_W-1:0]    dq_i,
  input  logic [BUS_W-1:0]    rd_word,
  output logic [LANES-1:0]    wr_be,
  output logic [BUS_W-1:0]    wr_data,
  output logic [BUS_W-1:0]    do_nxt,
  output logic [BUS_W-1:0]    oe_nxt
);
  logic              hi_sel;
  logic [LANE_W-1:0] id_code;
  logic [LANE_W-1:0] byte_rd;

  assign hi_sel  = dq_i[BUS_W-1];
  assign id_code = ID_BASE + ID_STEP * LANE_W'(id_sel);
  assign byte_rd = hi_sel ? rd_word[BUS_W-1:LANE_W] : rd_word[LANE_W-1:0];

  always_comb begin
    wr_be   = '0;
    wr_data = dq_i;
    oe_nxt  = '0;
    do_nxt  = '0;
    case (cyc)
      CYC_WRITE: begin
        if (word_mode) begin
          wr_be = '1;
        end else begin
          wr_be   = hi_sel ? 2'b10 : 2'b01;
          wr_data = {dq_i[LANE_W-1:0], dq_i[LANE_W-1:0]};
        end
      end
      CYC_READ: begin
        oe_nxt = word_mode ? {BUS_W{1'b1}} : {{LANE_W{1'b0}}, {LANE_W{1'b1}}};
        if (id_mode)        do_nxt = {{LANE_W{1'b0}}, id_code};
        else if (word_mode) do_nxt = rd_word;
        else                do_nxt = {{LANE_W{1'b0}}, byte_rd};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_bus_if.sv
`timescale 1ns/1ps
module flash_bus_if
  import flash_bus_pkg::*;
#(
  parameter int         ADDR_W   = 4,
  parameter int         ID_SEL_W = 2,
  parameter logic [7:0] ID_BASE  = 8'h01,
  parameter logic [7:0] ID_STEP  = 8'h22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_mode,
  input  logic              id_mode,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_i,
  output logic [15:0]       dq_o,
  output logic [15:0]       dq_oe
);
  cyc_e             cyc;
  logic [LANES-1:0] wr_be;
  logic [BUS_W-1:0] wr_data;
  logic [BUS_W-1:0] rd_word;
  logic [BUS_W-1:0] do_nxt;
  logic [BUS_W-1:0] oe_nxt;
  logic [BUS_W-1:0] do_q;
  logic [BUS_W-1:0] oe_q;

  flash_cycle_decode u_dec (
    .ce_n (ce_n),
    .oe_n (oe_n),
    .we_n (we_n),
    .cyc  (cyc)
  );

  flash_word_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_addr (addr),
    .wr_be   (wr_be),
    .wr_data (wr_data),
    .rd_addr (addr),
    .rd_data (rd_word)
  );

  flash_lane_path #(
    .ID_SEL_W (ID_SEL_W),
    .ID_BASE  (ID_BASE),
    .ID_STEP  (ID_STEP)
  ) u_path (
    .cyc       (cyc),
    .word_mode (word_mode),
    .id_mode   (id_mode),
    .id_sel    (addr[ID_SEL_W-1:0]),
    .dq_i      (dq_i),
    .rd_word   (rd_word),
    .wr_be     (wr_be),
    .wr_data   (wr_data),
    .do_nxt    (do_nxt),
    .oe_nxt    (oe_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      do_q <= '0;
      oe_q <= '0;
    end else begin
      do_q <= do_nxt;
      oe_q <= oe_nxt;
    end
  end

  assign dq_o  = do_q;
  assign dq_oe = oe_q;

  // R7
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (dq_oe == '0));

  // R6
  byte_hi_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_mode |=> (dq_oe[15:8] == '0));

  // R8
  contend_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !we_n) |=> (dq_oe == '0));

  // R8
  contend_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (wr_be == '0));

  // R2
  word_read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && we_n && word_mode) |=> (dq_oe == '1));

  // R9
  id_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && we_n && id_mode) |=> (dq_o[15:8] == '0));
endmodule

// File: tb/sim_flash_bus_if.sv
`timescale 1ns/1ps
module sim_flash_bus_if;
  logic        clk;
  logic        rst_n;
  logic        word_mode, id_mode, ce_n, oe_n, we_n;
  logic [3:0]  addr;
  logic [15:0] dq_i, dq_o, dq_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  flash_bus_if u0 (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .id_mode(id_mode),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [3:0]  rq;
    logic        wm, ce, oe, we, idm;
    logic [3:0]  a;
    logic [15:0] din, eoe, edo;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{4'd3,  1'b1,1'b0,1'b1,1'b0,1'b0, 4'd3, 16'hBEEF, 16'h0000, 16'h0000}, // R3 word write
    '{4'd2,  1'b1,1'b0,1'b0,1'b1,1'b0, 4'd3, 16'h0000, 16'hFFFF, 16'hBEEF}, // R2 word read
    '{4'd5,  1'b0,1'b0,1'b1,1'b0,1'b0, 4'd3, 16'h0012, 16'h0000, 16'h0000}, // R5 low byte write
    '{4'd4,  1'b0,1'b0,1'b0,1'b1,1'b0, 4'd3, 16'h0000, 16'h00FF, 16'h0012}, // R4 low byte read
    '{4'd4,  1'b0,1'b0,1'b0,1'b1,1'b0, 4'd3, 16'h8000, 16'h00FF, 16'h00BE}, // R4 high byte read
    '{4'd5,  1'b1,1'b0,1'b0,1'b1,1'b0, 4'd3, 16'h0000, 16'hFFFF, 16'hBE12}, // R5 high half kept
    '{4'd6,  1'b0,1'b0,1'b1,1'b0,1'b0, 4'd5, 16'hFF34, 16'h0000, 16'h0000}, // R6 junk on 14:8
    '{4'd6,  1'b1,1'b0,1'b0,1'b1,1'b0, 4'd5, 16'h0000, 16'hFFFF, 16'h3400}, // R6 only lane byte
    '{4'd6,  1'b0,1'b0,1'b0,1'b1,1'b0, 4'd5, 16'h7F00, 16'h00FF, 16'h0000}, // R6 junk in read
    '{4'd7,  1'b1,1'b1,1'b1,1'b0,1'b0, 4'd5, 16'h1111, 16'h0000, 16'h0000}, // R7 write deselected
    '{4'd7,  1'b1,1'b1,1'b0,1'b1,1'b0, 4'd5, 16'h0000, 16'h0000, 16'h0000}, // R7 read deselected
    '{4'd7,  1'b1,1'b0,1'b0,1'b1,1'b0, 4'd5, 16'h0000, 16'hFFFF, 16'h3400}, // R7 data intact
    '{4'd8,  1'b1,1'b0,1'b0,1'b0,1'b0, 4'd5, 16'h2222, 16'h0000, 16'h0000}, // R8 contended
    '{4'd8,  1'b1,1'b0,1'b0,1'b1,1'b0, 4'd5, 16'h0000, 16'hFFFF, 16'h3400}, // R8 data intact
    '{4'd9,  1'b1,1'b0,1'b0,1'b1,1'b1, 4'd2, 16'h0000, 16'hFFFF, 16'h0045}, // R9 word id read
    '{4'd9,  1'b0,1'b0,1'b0,1'b1,1'b1, 4'd1, 16'h8000, 16'h00FF, 16'h0023}, // R9 byte id read
    '{4'd11, 1'b1,1'b0,1'b1,1'b1,1'b0, 4'd5, 16'h0000, 16'h0000, 16'h0000}, // R11 idle
    '{4'd9,  1'b1,1'b0,1'b1,1'b0,1'b1, 4'd6, 16'hABCD, 16'h0000, 16'h0000}, // R9 write in id mode
    '{4'd10, 1'b1,1'b0,1'b0,1'b1,1'b0, 4'd6, 16'h0000, 16'hFFFF, 16'hABCD}, // R10 read after write
    '{4'd9,  1'b1,1'b0,1'b0,1'b1,1'b1, 4'd0, 16'h0000, 16'hFFFF, 16'h0001}  // R9 id index 0
  };

  task automatic drive(input logic wm, input logic c, input logic o, input logic w,
                       input logic idm, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    word_mode = wm; ce_n = c; oe_n = o; we_n = w; id_mode = idm; addr = a; dq_i = d;
  endtask

  task automatic check(input int rq, input logic [15:0] eoe, input logic [15:0] edo);
    checks++;
    if (dq_oe !== eoe || (dq_o & eoe) !== edo) begin
      errors++;
      $display("FAIL R%0d: oe=%h data=%h expected oe=%h data=%h", rq, dq_oe, dq_o & eoe, eoe, edo);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    word_mode = 1'b1; id_mode = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    addr = '0; dq_i = '0;
    repeat (3) @(posedge clk);
    #1 check(1, 16'h0000, 16'h0000); // R1 outputs quiet in reset
    @(negedge clk) rst_n = 1'b1;
    drive(1, 0, 0, 1, 0, 4'd3, 16'h0);
    @(posedge clk); #1 check(1, 16'hFFFF, 16'h0000); // R1 array cleared

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].wm, VEC[i].ce, VEC[i].oe, VEC[i].we, VEC[i].idm, VEC[i].a, VEC[i].din);
      @(posedge clk); #1 check(int'(VEC[i].rq), VEC[i].eoe, VEC[i].edo);
    end

    // R10: output holds until the edge that samples the read
    drive(1, 0, 1, 1, 0, 4'd3, 16'h0);
    @(posedge clk); #1;
    drive(1, 0, 0, 1, 0, 4'd3, 16'h0);
    #1 check(10, 16'h0000, 16'h0000);
    @(posedge clk); #1 check(10, 16'hFFFF, 16'hBE12);

    // R10: drive stops on the edge after oe_n rises
    drive(1, 0, 1, 1, 0, 4'd3, 16'h0);
    #1 check(10, 16'hFFFF, 16'hBE12);
    @(posedge clk); #1 check(10, 16'h0000, 16'h0000);

    // R1: reset mid-run clears outputs at once and wipes the array
    drive(1, 0, 0, 1, 0, 4'd3, 16'h0);
    @(posedge clk); #1;
    @(negedge clk) rst_n = 1'b0;
    #1 check(1, 16'h0000, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 check(1, 16'hFFFF, 16'h0000);

    // R5: high byte write then low byte write on a fresh word
    drive(0, 0, 1, 0, 0, 4'd9, 16'h80A5);
    drive(0, 0, 1, 0, 0, 4'd9, 16'h005A);
    drive(1, 0, 0, 1, 0, 4'd9, 16'h0);
    @(posedge clk); #1 check(5, 16'hFFFF, 16'hA55A);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule